// File: doc/BRIEF.md
# Free-Running Tick Counter with Sticky Overflow Flag

This block is a free-running up-counter that advances one step on each enabled tick. When it rolls over from all ones to zero, it raises a sticky overflow flag. Software reads the counter and the flag over a small byte-wide register bus, and a masked interrupt request follows the flag.

The flag can be cleared in two ways. The first is a write-one-to-clear on the flag register, which only works while the timer or the pulse accumulator is switched on. The second is a fast-clear mode: when it is selected, any bus access to the counter bytes clears the flag. Reading the high counter byte also captures the low byte, so a following low-byte read gives a coherent 16-bit value. Any address that is not mapped, such as the slot of a missing capture channel, reads as zero and ignores writes.

Top module: `frt_overflow_timer`

## Requirements
- R1: The 16-bit counter wraps from 0xFFFF to 0x0000 on an enabled tick, and that wrap sets the overflow flag.
- R2: The flag register at address 2 can be read at any time. It returns the flag in bit 7, and bits 6 to 0 always read as zero.
- R3: A write to address 2 with bit 7 equal to zero leaves the flag unchanged.
- R4: A write to address 2 with bit 7 equal to one clears the flag only while the timer enable or the pulse-accumulator enable is one. Otherwise the write is ignored.
- R5: While fast clear is one, any read or write of address 0 or address 1 clears the flag. While fast clear is zero, accesses to those addresses leave the flag unchanged.
- R6: The counter advances by one only in cycles where both the timer enable and the tick input are one. Reset sets the counter, the flag, the read data and the interrupt request to zero.
- R7: A read of address 0 returns the counter's upper byte and captures its lower byte. A read of address 1 returns the captured byte, even if the counter has moved since the capture.
- R8: A read of any address other than 0, 1 and 2 returns zero, and a write to such an address changes nothing.
- R9: The interrupt request equals the flag ANDed with the overflow interrupt enable, registered one cycle later.
- R10: When a wrap and a clear occur in the same cycle, the flag ends up set.
- R11: Read data appears one cycle after the read strobe and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tmr_en | input | 1 | Timer enable |
| pacc_en | input | 1 | Pulse-accumulator enable |
| fast_clr | input | 1 | Selects clear-on-counter-access |
| tick_en | input | 1 | Counter tick qualifier |
| ovf_ie | input | 1 | Overflow interrupt enable |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest state to reach is the exact cycle of the rollover, because it only comes after 65,535 enabled ticks. The bench tracks the count in its model and adds exactly the number of ticks needed to park the counter at 0xFFFF. It then does this twice. In the first wrap it tries every clear path one at a time. In the second wrap, a write-one clear is issued on the same edge as the final tick, to show that the new overflow is kept.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned FLAG_POS = 7;
  localparam logic [DATA_W-1:0] FLAG_MASK = 8'h80;
  localparam int unsigned SLOT_CNT_HI = 0;
  localparam int unsigned SLOT_CNT_LO = 1;
  localparam int unsigned SLOT_FLAG   = 2;
endpackage

// File: rtl/frt_counter.sv
module frt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tmr_en,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic adv;
  assign adv  = tmr_en & tick_en;
  assign wrap = adv && (cnt == CNT_TOP);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (adv) cnt <= cnt + 1'b1;
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(tmr_en && tick_en) |=> $stable(cnt)); // R6
  AST_CNT_ROLL: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0)); // R1
endmodule

// File: rtl/frt_flag.sv
module frt_flag (
  input  logic clk,
  input  logic rst,
  input  logic wrap,
  input  logic w1c_req,
  input  logic clr_allow,
  input  logic fast_req,
  output logic flag_q
);
  logic clr;
  assign clr = (w1c_req & clr_allow) | fast_req;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else if (wrap) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  AST_OVF_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flag_q); // R1
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wrap && (w1c_req || fast_req)) |=> flag_q); // R10
  AST_LOCKED_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !fast_req && !clr_allow) |=> flag_q); // R4
endmodule

// File: rtl/frt_regif.sv
module frt_regif
  import frt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              flag_q,
  output logic              cnt_acc,
  output logic              flag_wr,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(SLOT_CNT_HI);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(SLOT_CNT_LO);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(SLOT_FLAG);

  logic sel_hi, sel_lo, sel_flag;
  logic [DATA_W-1:0] lo_latch;
  logic [DATA_W-1:0] rd_mux;

  assign sel_hi   = (bus_addr == A_HI);
  assign sel_lo   = (bus_addr == A_LO);
  assign sel_flag = (bus_addr == A_FLAG);
  assign cnt_acc  = (bus_rd | bus_wr) & (sel_hi | sel_lo);
  assign flag_wr  = bus_wr & sel_flag;

  always_comb begin
    rd_mux = '0;
    if (sel_hi)        rd_mux = cnt[CNT_W-1 -: DATA_W];
    else if (sel_lo)   rd_mux = lo_latch;
    else if (sel_flag) rd_mux[FLAG_POS] = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_latch  <= '0;
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
      if (sel_hi) lo_latch <= cnt[DATA_W-1:0];
    end
  end

  AST_FLAG_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel_flag) |=> ((bus_rdata & ~FLAG_MASK) == '0)); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !sel_hi && !sel_lo && !sel_flag) |=> (bus_rdata == '0)); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R11
endmodule

// File: rtl/frt_overflow_timer.sv
module frt_overflow_timer
  import frt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              tmr_en,
  input  logic              pacc_en,
  input  logic              fast_clr,
  input  logic              tick_en,
  input  logic              ovf_ie,
  output logic              irq
);
  logic [CNT_W-1:0] cnt;
  logic wrap, flag_q, cnt_acc, flag_wr;
  logic w1c_req, fast_req, clr_allow;

  assign w1c_req   = flag_wr & (|(bus_wdata & FLAG_MASK));
  assign fast_req  = fast_clr & cnt_acc;
  assign clr_allow = tmr_en | pacc_en;

  frt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tmr_en(tmr_en), .tick_en(tick_en),
    .cnt(cnt), .wrap(wrap)
  );

  frt_flag u_flag (
    .clk(clk), .rst(rst), .wrap(wrap), .w1c_req(w1c_req),
    .clr_allow(clr_allow), .fast_req(fast_req), .flag_q(flag_q)
  );

  frt_regif #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .cnt(cnt), .flag_q(flag_q),
    .cnt_acc(cnt_acc), .flag_wr(flag_wr), .bus_rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else irq <= flag_q & ovf_ie;
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    !ovf_ie |=> !irq); // R9
  AST_FAST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (fast_req && !wrap) |=> !flag_q); // R5
endmodule

// File: tb/frt_overflow_timer_tb.sv
module frt_overflow_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic tmr_en = 1'b0, pacc_en = 1'b0, fast_clr = 1'b0, tick_en = 1'b0, ovf_ie = 1'b0;
  logic irq;

  int checks = 0;
  int errors = 0;
  string cur_req = "R6";

  int m_cnt = 0, m_latch = 0, m_rdata = 0;
  bit m_flag = 0, m_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frt_overflow_timer dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_en(tmr_en), .pacc_en(pacc_en),
    .fast_clr(fast_clr), .tick_en(tick_en), .ovf_ie(ovf_ie), .irq(irq)
  );

  // behavioural reference, evaluated on every rising edge
  always @(posedge clk) begin
    bit wrap_m, clr_m;
    if (rst) begin
      m_cnt = 0; m_flag = 0; m_latch = 0; m_rdata = 0; m_irq = 0;
    end else begin
      m_irq  = m_flag && ovf_ie;
      wrap_m = tmr_en && tick_en && (m_cnt == 65535);
      if (bus_rd) begin
        if (bus_addr == 0) begin m_rdata = m_cnt / 256; m_latch = m_cnt % 256; end
        else if (bus_addr == 1) m_rdata = m_latch;
        else if (bus_addr == 2) m_rdata = m_flag ? 128 : 0;
        else m_rdata = 0;
      end
      clr_m = (bus_wr && bus_addr == 2 && bus_wdata[7] && (tmr_en || pacc_en)) ||
              (fast_clr && (bus_rd || bus_wr) && bus_addr < 2);
      if (wrap_m) m_flag = 1;
      else if (clr_m) m_flag = 0;
      if (tmr_en && tick_en) m_cnt = (m_cnt + 1) % 65536;
    end
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check({cur_req, " rdata"}, bus_rdata, m_rdata);
      check("R9 irq", irq, m_irq);
    end
  end

  task automatic bus_read(input int a, output int d);
    @(negedge clk); bus_addr = 4'(a); bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic bus_write(input int a, input int v);
    @(negedge clk); bus_addr = 4'(a); bus_wdata = 8'(v); bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk); tmr_en = 1'b1; tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R6";
    check("R6 reset rdata", bus_rdata, 0);
    check("R6 reset irq", irq, 0);
    cur_req = "R2";
    bus_read(2, d); check("R2 flag after reset", d, 0);
    cur_req = "R7";
    bus_read(0, d); check("R7 hi after reset", d, 0);
    bus_read(1, d); check("R7 lo after reset", d, 0);

    // ticks with timer disabled must not count
    cur_req = "R6";
    @(negedge clk); tick_en = 1'b1; tmr_en = 1'b0;
    repeat (10) @(negedge clk);
    tick_en = 1'b0;
    bus_read(0, d); check("R6 no count while disabled hi", d, 0);
    bus_read(1, d); check("R6 no count while disabled lo", d, 0);

    cur_req = "R7";
    run_ticks(300);
    bus_read(0, d); check("R7 hi byte", d, 8'h01);
    run_ticks(5);
    bus_read(1, d); check("R7 lo byte coherent", d, 8'h2C);
    bus_read(0, d); check("R7 hi byte after move", d, 8'h01);
    bus_read(1, d); check("R7 lo byte after move", d, 8'h31);

    cur_req = "R11";
    repeat (3) @(negedge clk);
    check("R11 rdata holds", bus_rdata, 8'h31);

    cur_req = "R8";
    bus_write(5, 8'hFF);
    bus_read(5, d); check("R8 unmapped slot", d, 0);
    bus_read(15, d); check("R8 top slot", d, 0);
    bus_read(2, d); check("R8 flag untouched", d, 0);

    // first rollover
    cur_req = "R1";
    run_ticks(65535 - m_cnt);
    bus_read(2, d); check("R1 flag before wrap", d, 0);
    ovf_ie = 1'b1;
    run_ticks(1);
    bus_read(2, d); check("R1 flag after wrap", d, 8'h80);
    bus_read(0, d); check("R1 counter wrapped", d, 0);
    cur_req = "R9";
    check("R9 irq asserted", irq, 1);
    @(negedge clk); ovf_ie = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 irq masked", irq, 0);
    ovf_ie = 1'b1;

    cur_req = "R4";
    tmr_en = 1'b0; pacc_en = 1'b0;
    bus_write(2, 8'h80);
    bus_read(2, d); check("R4 clear ignored when disabled", d, 8'h80);
    cur_req = "R3";
    tmr_en = 1'b1;
    bus_write(2, 8'h7F);
    bus_read(2, d); check("R3 zero bit keeps flag", d, 8'h80);
    cur_req = "R5";
    fast_clr = 1'b0;
    bus_read(0, d);
    bus_write(1, 8'h00);
    bus_read(2, d); check("R5 no fast clear when off", d, 8'h80);
    fast_clr = 1'b1;
    bus_read(1, d);
    fast_clr = 1'b0;
    bus_read(2, d); check("R5 fast clear on counter read", d, 0);
    repeat (2) @(negedge clk);
    check("R9 irq follows cleared flag", irq, 0);

    // second rollover with a simultaneous clear
    cur_req = "R10";
    run_ticks(65535 - m_cnt);
    @(negedge clk);
    tmr_en = 1'b1; tick_en = 1'b1;
    bus_addr = 4'd2; bus_wdata = 8'h80; bus_wr = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; bus_wr = 1'b0;
    bus_read(2, d); check("R10 set wins over clear", d, 8'h80);

    cur_req = "R4";
    tmr_en = 1'b0; pacc_en = 1'b1;
    bus_write(2, 8'h80);
    bus_read(2, d); check("R4 clear via accumulator enable", d, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule